// File: doc/BRIEF.md
# Multi-Channel Aligned PWM Generator

The block drives several pulse-width-modulated outputs, each from its own counter, all clocked from one clock. Every channel has a period, a pulse width and a phase offset. Software writes new values into per-channel shadow registers through a small write port. A load request then moves all channels to the new values at one common instant. Because all channels restart on the same clock edge, their phase relationship is set only by their offsets.

A reload never cuts a channel off in the middle of a period. After a request, each running channel plays out the rest of its current period and then stops with its output low. When every channel has stopped, all of them restart together on the shadow values. If external synchronisation is enabled, the restart waits for a rising edge on the sync input. A busy flag stays high from the request until the restart.

Top module: `aligned_pwm`

## Requirements
- R1: A running channel's counter goes 0, 1, ..., period-1 and then wraps to 0. The output is high while offset <= count < offset + width, for period >= 1 and offset < period.
- R2: A width of 0 keeps the output low. A width greater than or equal to the period keeps the output high for the whole period.
- R3: A write with wr_field 0, 1 or 2 stores wr_data as the period, width or offset of channel wr_ch in its shadow register. A channel index of NUM_CH or higher is ignored. Shadow values reach a channel only at a restart, so writes made while a channel runs or waits do not change its output.
- R4: A write with wr_field 3 and wr_data bit 0 set is a load request. busy is high from the cycle after the request until the restart edge, and low at that edge.
- R5: After a load request, each running channel completes its current period. It stops at the first wrap edge that follows the request edge, and its output then stays low.
- R6: With sync disabled, all channels restart at the first clock edge on which every channel is already stopped. At that edge the counters load 0 and the new settings, so the first pulse falls in the first period (a channel with offset 0 is high in the first cycle).
- R7: A channel that stops early, including a channel with offset 0, stays low until the common restart.
- R8: wr_data bit 1 of a wr_field 3 write sets the sync enable. With sync enabled, the restart needs a rising edge on sync_in that arrives while all channels are stopped and a request is pending. Rising edges that arrive while channels are still draining are ignored.
- R9: After reset, all outputs are low, busy is low and every channel is stopped. The first load request starts all channels from this stopped state.
- R10: A load request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel index for the write |
| wr_field | input | 2 | 0 period, 1 width, 2 offset, 3 control |
| wr_data | input | CNT_W | Write data (control: bit 0 load, bit 1 sync enable) |
| sync_in | input | 1 | External sync, rising edge is the event |
| pwm_out | output | NUM_CH | PWM output per channel |
| busy | output | 1 | Reload pending |

## Verification
The bench sweeps period, width and offset on one channel, including widths of 0, equal to the period and above it. A window compare with an off-by-one error, or a missing saturation case, would show up as a wrong duty cycle at those points. It places reload requests just after a restart, while a slow channel keeps a fast zero-offset channel waiting. A design that restarted that fast channel alone, or cut the slow channel off mid-period, would produce pulses that the model does not expect. It pulses sync during the drain and then holds off the sync edge for many cycles. A design that latched the early edge, or ignored the sync enable, would drop busy too soon. Repeated requests while busy and shadow writes during a run check that neither one disturbs the running pattern.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  typedef enum logic [1:0] {
    FLD_PERIOD = 2'd0,
    FLD_WIDTH  = 2'd1,
    FLD_OFFSET = 2'd2,
    FLD_CTRL   = 2'd3
  } apwm_field_e;

  localparam int CTRL_LOAD_BIT = 0;
  localparam int CTRL_SYNC_BIT = 1;
endpackage

// File: rtl/apwm_sync_edge.sv
module apwm_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_evt
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign sync_evt = sync_in && !sync_q;
endmodule

// File: rtl/apwm_channel.sv
module apwm_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             drain,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [CNT_W-1:0] sh_wid,
  input  logic [CNT_W-1:0] sh_off,
  output logic             pwm,
  output logic             running,
  output logic             period_end
);
  logic [CNT_W-1:0] cnt_q, act_per, act_wid, act_off;
  logic             run_q;

  function automatic logic at_last(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return ({1'b0, c} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, p};
  endfunction

  function automatic logic level_at(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p,
                                    input logic [CNT_W-1:0] w, input logic [CNT_W-1:0] o);
    if (w == '0)  return 1'b0;
    if (w >= p)   return 1'b1;
    return ({1'b0, c} >= {1'b0, o}) && ({1'b0, c} < ({1'b0, o} + {1'b0, w}));
  endfunction

  assign period_end = run_q && at_last(cnt_q, act_per);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      act_per <= '0;
      act_wid <= '0;
      act_off <= '0;
    end else if (restart) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      act_per <= sh_per;
      act_wid <= sh_wid;
      act_off <= sh_off;
    end else if (run_q) begin
      if (period_end) begin
        cnt_q <= '0;
        if (drain) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pwm     = run_q && level_at(cnt_q, act_per, act_wid, act_off);
  assign running = run_q;

  // R5: a channel only stops at the end of a period while draining
  assert_stop_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(period_end && drain));
  // R7: a channel only starts on the common restart
  assert_no_early_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(restart));
  // R3: active settings do not move without a restart
  assert_active_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(act_per) && $stable(act_wid) && $stable(act_off));
  // R2: zero width never drives high
  assert_zero_width_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_wid == '0) |-> !pwm);
endmodule

// File: rtl/apwm_reload_ctrl.sv
module apwm_reload_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic cfg_wr,
  input  logic cfg_sync_en,
  input  logic all_stopped,
  input  logic sync_evt,
  output logic pending,
  output logic sync_en,
  output logic restart
);
  logic pend_q, sync_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      sync_en_q <= 1'b0;
    end else begin
      if (cfg_wr) sync_en_q <= cfg_sync_en;
      if (restart)       pend_q <= 1'b0;
      else if (load_req) pend_q <= 1'b1;
    end
  end

  assign restart = pend_q && all_stopped && (!sync_en_q || sync_evt);
  assign pending = pend_q;
  assign sync_en = sync_en_q;

  // R4: busy holds until the restart edge
  assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !restart |=> pend_q);
endmodule

// File: rtl/aligned_pwm.sv
module aligned_pwm
  import apwm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [1:0]        wr_field,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              sync_in,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              busy
);
  logic [CNT_W-1:0]  sh_per [NUM_CH];
  logic [CNT_W-1:0]  sh_wid [NUM_CH];
  logic [CNT_W-1:0]  sh_off [NUM_CH];
  logic [NUM_CH-1:0] running, period_end;
  logic              sync_evt, restart, sync_en, all_stopped;
  logic              cfg_wr, load_req;

  assign cfg_wr      = wr_en && (apwm_field_e'(wr_field) == FLD_CTRL);
  assign load_req    = cfg_wr && wr_data[CTRL_LOAD_BIT];
  assign all_stopped = ~|running;

  apwm_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_evt(sync_evt)
  );

  apwm_reload_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .cfg_wr(cfg_wr),
    .cfg_sync_en(wr_data[CTRL_SYNC_BIT]), .all_stopped(all_stopped),
    .sync_evt(sync_evt), .pending(busy), .sync_en(sync_en), .restart(restart)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_ch == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_per[i] <= '0;
        sh_wid[i] <= '0;
        sh_off[i] <= '0;
      end else if (sel) begin
        case (apwm_field_e'(wr_field))
          FLD_PERIOD: sh_per[i] <= wr_data;
          FLD_WIDTH:  sh_wid[i] <= wr_data;
          FLD_OFFSET: sh_off[i] <= wr_data;
          default: ;
        endcase
      end
    end

    apwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .restart(restart), .drain(busy),
      .sh_per(sh_per[i]), .sh_wid(sh_wid[i]), .sh_off(sh_off[i]),
      .pwm(pwm_out[i]), .running(running[i]), .period_end(period_end[i])
    );
  end

  // R6: all channels run together right after a restart
  assert_aligned_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> &running);
  // R5: busy only drops once every channel has stopped
  assert_drained_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(all_stopped));
  // R8: with sync enabled the restart needs a sync edge
  assert_sync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(sync_en) |-> $past(sync_evt));
  // R4: busy only rises on a load request
  assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_req));
endmodule

// File: tb/aligned_pwm_bench.sv
`timescale 1ns/1ps
module aligned_pwm_bench;
  localparam int NCH = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [1:0] wr_field = '0;
  logic [7:0] wr_data = '0;
  logic       sync_in = 1'b0;
  logic [2:0] pwm_out;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string tag = "R9";

  always #10 clk = ~clk;

  aligned_pwm #(.NUM_CH(NCH), .CNT_W(8)) u_aligned_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_field(wr_field),
    .wr_data(wr_data), .sync_in(sync_in), .pwm_out(pwm_out), .busy(busy)
  );

  // Reference model built from the requirements
  int m_cnt [NCH], m_per [NCH], m_wid [NCH], m_off [NCH];
  int s_per [NCH], s_wid [NCH], s_off [NCH];
  bit m_run [NCH];
  bit m_pend, m_se, m_sq;
  bit any_run, sev, rs;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] <= 0; m_run[c] <= 0; m_per[c] <= 0; m_wid[c] <= 0; m_off[c] <= 0;
        s_per[c] <= 0; s_wid[c] <= 0; s_off[c] <= 0;
      end
      m_pend <= 0; m_se <= 0; m_sq <= 0;
    end else begin
      any_run = 0;
      for (int c = 0; c < NCH; c++) any_run = any_run | m_run[c];
      sev = sync_in && !m_sq;
      rs  = m_pend && !any_run && (!m_se || sev);
      for (int c = 0; c < NCH; c++) begin
        if (rs) begin
          m_run[c] <= 1; m_cnt[c] <= 0;
          m_per[c] <= s_per[c]; m_wid[c] <= s_wid[c]; m_off[c] <= s_off[c];
        end else if (m_run[c]) begin
          if (m_cnt[c] + 1 >= m_per[c]) begin
            m_cnt[c] <= 0;
            if (m_pend) m_run[c] <= 0;
          end else m_cnt[c] <= m_cnt[c] + 1;
        end
      end
      if (wr_en && wr_ch < NCH) begin
        if (wr_field == 2'd0) s_per[wr_ch] <= wr_data;
        if (wr_field == 2'd1) s_wid[wr_ch] <= wr_data;
        if (wr_field == 2'd2) s_off[wr_ch] <= wr_data;
      end
      if (wr_en && wr_field == 2'd3) m_se <= wr_data[1];
      if (rs) m_pend <= 0;
      else if (wr_en && wr_field == 2'd3 && wr_data[0]) m_pend <= 1;
      m_sq <= sync_in;
    end
  end

  function automatic bit exp_level(int c);
    int pos;
    if (!m_run[c] || m_wid[c] == 0) return 0;
    if (m_wid[c] >= m_per[c]) return 1;
    pos = m_cnt[c] - m_off[c];
    return (pos >= 0) && (pos < m_wid[c]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one edge, then compare every output with the model
  task automatic tick();
    @(posedge clk); #2;
    for (int c = 0; c < NCH; c++)
      check(pwm_out[c] == exp_level(c), tag, pwm_out[c], exp_level(c));
    check(busy == m_pend, {tag, " busy"}, busy, m_pend);
  endtask

  task automatic wr(int ch, int fld, int data);
    wr_en = 1; wr_ch = 2'(ch); wr_field = 2'(fld); wr_data = 8'(data);
    tick();
    wr_en = 0;
  endtask

  task automatic setch(int ch, int p, int w, int o);
    wr(ch, 0, p); wr(ch, 1, w); wr(ch, 2, o);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    check(pwm_out == 3'b000, "R9 reset pwm", pwm_out, 0);
    check(busy == 1'b0, "R9 reset busy", busy, 0);

    tag = "R1+R9 first start";
    setch(0, 4, 2, 0); setch(1, 6, 3, 2); setch(2, 5, 0, 1);
    wr(0, 3, 1);
    check(busy == 1'b1, "R4 busy after request", busy, 1);
    tick();
    check(busy == 1'b0, "R6 restart edge", busy, 0);
    check(pwm_out[0] == 1'b1, "R6 first cycle offset 0", pwm_out[0], 1);
    check(pwm_out[1] == 1'b0, "R6 offset 2 not yet", pwm_out[1], 0);
    repeat (40) tick();

    tag = "R3 shadow writes while running";
    setch(0, 3, 3, 0);
    wr(3, 0, 9);
    repeat (20) tick();

    tag = "R1+R2 sweep";
    setch(0, 3, 1, 0); setch(2, 5, 2, 3);
    for (int p = 3; p <= 6; p++)
      for (int w = 0; w <= p + 1; w++)
        for (int o = 0; o < p; o++) begin
          setch(1, p, w, o);
          wr(0, 3, 1);
          wait_idle();
          repeat (2 * p + 3) tick();
        end

    tag = "R5+R7 zero offset wait";
    setch(0, 2, 1, 0); setch(1, 12, 5, 0); setch(2, 3, 3, 0);
    wr(0, 3, 1); wait_idle();
    wr(0, 3, 1);
    repeat (4) tick();
    check(pwm_out[0] == 1'b0, "R7 early channel held low", pwm_out[0], 0);
    check(busy == 1'b1, "R5 slow channel still draining", busy, 1);
    tag = "R10 request while busy";
    wr(0, 3, 1);
    wait_idle();
    repeat (2) tick();
    check(busy == 1'b0, "R10 second request ignored", busy, 0);
    repeat (15) tick();

    tag = "R8 sync gated restart";
    wr(0, 3, 3);
    tick();
    sync_in = 1; tick(); sync_in = 0;
    repeat (40) tick();
    check(busy == 1'b1, "R8 no restart without sync edge", busy, 1);
    check(pwm_out == 3'b000, "R8 outputs low while waiting", pwm_out, 0);
    sync_in = 1; tick();
    check(busy == 1'b0, "R8 restart on sync edge", busy, 0);
    repeat (3) tick();
    sync_in = 0;
    wr(0, 3, 0);
    repeat (20) tick();

    tag = "R6 restart without sync";
    setch(1, 5, 2, 4);
    wr(0, 3, 1); wait_idle();
    repeat (20) tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule